// File: doc/BRIEF.md
# PCM and Codec Bit-Clock Selector

This block picks the bit clock for a PCM port and for a codec port from four candidates each: an external clock pin, a divided master clock, a divided synthesized clock, or the synthesized clock as it stands. Every part of the block, including the output clocks, is built as registered levels in the master-clock domain. The synthesized clock arrives as a level that is already synchronous to the master clock. The external PCM clock pin passes through a two-flop synchronizer. Each port has its own divisors. A source select passes through a synchronizer. The block then switches only while the outgoing clock is low. After the switch it holds the output low until the new source has risen three times and is low again, so neither a short high pulse nor a short low pulse appears.

The PCM port's role follows from its source. With the external pin selected the port is a slave: the frame output repeats the external frame pin and its output enable is off. With any other source the port is the master: a frame pulse is made inside the block from the PCM clock, one PCM-clock high phase long, once every programmable number of PCM clocks, and the frame output enable is on. The codec port can never take a clock in on its own pin. Its external choice is the PCM clock pin. Its clock pin driver stays off after reset until a configuration bit turns it on.

Top module: `pcm_codec_clksel`

## Requirements
- R1: Source select encoding, for each port: 0 = external pin, 1 = master clock divided (high for N master cycles, then low for N), 2 = synthesized clock divided (high for N synthesized periods, then low for N), 3 = synthesized clock undivided. Once settled, the output repeats the chosen source's high and low widths.
- R2: For the codec port, source 0 is the PCM clock pin. Its output then has the same high and low widths as that pin.
- R3: `pcm_master_o` is 1 exactly when the settled PCM source is not 0, and `pcm_frm_oe_o` always equals `pcm_master_o`.
- R4: In slave mode, `pcm_frm_o` follows `pcm_frm_pin_i` within the same cycle, and `pcm_frm_oe_o` is 0.
- R5: In master mode, `pcm_frm_o` is high only while `pcm_clk_o` is high. It goes high together with a rise of `pcm_clk_o`, lasts one PCM high phase, and repeats every `frm_period_i` PCM clock periods.
- R6: `frm_period_i` = 0 selects a frame period of 256 PCM clocks.
- R7: `cod_clk_oe_o` is 0 from reset. It follows `cod_oe_bit_i` with one master-clock cycle of delay.
- R8: On a source change, a high phase already under way finishes at its full width. The output then stays low for at least two periods of the new source, and the first new high phase has full width. `pcm_master_o` changes only while `pcm_clk_o` is low.
- R9: During and straight after reset, both clock outputs are low, the PCM port is a slave, and the codec clock driver is off.
- R10: A divisor of 0 behaves as a divisor of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; every register runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| pll_clk_i | input | 1 | Synthesized clock level, synchronous to mclk |
| pcm_clk_pin_i | input | 1 | External PCM clock pin (asynchronous) |
| pcm_frm_pin_i | input | 1 | External PCM frame pin |
| pcm_src_i | input | 2 | PCM clock source select (R1 encoding) |
| cod_src_i | input | 2 | Codec clock source select (R1 encoding) |
| pcm_mdiv_i | input | DIV_W | PCM master-clock divisor |
| pcm_pdiv_i | input | DIV_W | PCM synthesized-clock divisor |
| cod_mdiv_i | input | DIV_W | Codec master-clock divisor |
| cod_pdiv_i | input | DIV_W | Codec synthesized-clock divisor |
| frm_period_i | input | FRM_W | Frame period in PCM clocks; 0 means 256 |
| cod_oe_bit_i | input | 1 | Codec clock pin output-enable bit |
| pcm_clk_o | output | 1 | Selected PCM bit clock |
| cod_clk_o | output | 1 | Selected codec bit clock |
| pcm_master_o | output | 1 | PCM port is the master |
| pcm_frm_o | output | 1 | Frame pulse toward the frame pin |
| pcm_frm_oe_o | output | 1 | Frame pin output enable |
| cod_clk_oe_o | output | 1 | Codec clock pin output enable |

## Verification
Two things can happen in the same cycle: a source switch, and a frame-pulse or clock edge that is under way. The master role also changes on a switch. The bench changes the PCM select on the very cycle the clock output has just gone high. It then measures three things: the width of the pulse that was cut into, the low gap, and the first new pulse. These are compared with the widths of the old and new sources. The checker confirms that the frame pulse never stands outside a PCM high phase and that the master role never flips while the clock is high.

// File: rtl/pcm_codec_clksel.sv
module pcm_codec_clksel #(
  parameter int DIV_W      = 8,
  parameter int FRM_W      = 9,
  parameter int DEF_FRAME  = 256,
  parameter int HOLD_RISES = 3
) (
  input  logic             mclk,
  input  logic             rst_n,
  input  logic             pll_clk_i,
  input  logic             pcm_clk_pin_i,
  input  logic             pcm_frm_pin_i,
  input  logic [1:0]       pcm_src_i,
  input  logic [1:0]       cod_src_i,
  input  logic [DIV_W-1:0] pcm_mdiv_i,
  input  logic [DIV_W-1:0] pcm_pdiv_i,
  input  logic [DIV_W-1:0] cod_mdiv_i,
  input  logic [DIV_W-1:0] cod_pdiv_i,
  input  logic [FRM_W-1:0] frm_period_i,
  input  logic             cod_oe_bit_i,
  output logic             pcm_clk_o,
  output logic             cod_clk_o,
  output logic             pcm_master_o,
  output logic             pcm_frm_o,
  output logic             pcm_frm_oe_o,
  output logic             cod_clk_oe_o
);
  localparam int HC_W = $clog2(HOLD_RISES + 1);

  logic [1:0] pin_sync;
  logic       ext_clk, pll_q, pll_rise;
  logic       port_clk  [2];
  logic       port_hold [2];
  logic       port_rise [2];
  logic [1:0] port_cur  [2];

  always_ff @(posedge mclk or negedge rst_n)
    if (!rst_n) begin
      pin_sync <= '0;
      pll_q    <= 1'b0;
    end else begin
      pin_sync <= {pin_sync[0], pcm_clk_pin_i};
      pll_q    <= pll_clk_i;
    end

  assign ext_clk  = pin_sync[1];
  assign pll_rise = pll_clk_i & ~pll_q;

  for (genvar p = 0; p < 2; p++) begin : g_port
    logic [DIV_W-1:0] mdv, pdv, mhalf, phalf, mcnt, pcnt;
    logic [1:0]       cfg, s1, s2, cur;
    logic [3:0]       src, src_q, src_rise;
    logic             mclk_dv, pll_dv, hold, clk_r, nxt;
    logic [HC_W-1:0]  hcnt;

    assign mdv   = (p == 0) ? pcm_mdiv_i : cod_mdiv_i;
    assign pdv   = (p == 0) ? pcm_pdiv_i : cod_pdiv_i;
    assign cfg   = (p == 0) ? pcm_src_i  : cod_src_i;
    assign mhalf = (mdv == '0) ? DIV_W'(1) : mdv;
    assign phalf = (pdv == '0) ? DIV_W'(1) : pdv;

    assign src      = {pll_clk_i, pll_dv, mclk_dv, ext_clk};
    assign src_rise = src & ~src_q;
    assign nxt      = hold ? 1'b0 : src[cur];

    always_ff @(posedge mclk or negedge rst_n)
      if (!rst_n) begin
        mcnt    <= '0;
        mclk_dv <= 1'b0;
        pcnt    <= '0;
        pll_dv  <= 1'b0;
        src_q   <= '0;
        s1      <= '0;
        s2      <= '0;
      end else begin
        src_q <= src;
        s1    <= cfg;
        s2    <= s1;
        if (mcnt >= mhalf - 1'b1) begin
          mcnt    <= '0;
          mclk_dv <= ~mclk_dv;
        end else begin
          mcnt <= mcnt + 1'b1;
        end
        if (pll_rise) begin
          if (pcnt >= phalf - 1'b1) begin
            pcnt   <= '0;
            pll_dv <= ~pll_dv;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
      end

    always_ff @(posedge mclk or negedge rst_n)
      if (!rst_n) begin
        cur   <= 2'd0;
        hold  <= 1'b1;
        hcnt  <= '0;
        clk_r <= 1'b0;
      end else begin
        clk_r <= nxt;
        if (hold) begin
          if (s2 != cur) begin
            cur  <= s2;
            hcnt <= '0;
          end else if (hcnt != HC_W'(HOLD_RISES)) begin
            if (src_rise[cur]) hcnt <= hcnt + 1'b1;
          end else if (!src[cur]) begin
            hold <= 1'b0;
          end
        end else if (s2 != cur && !src[cur]) begin
          cur  <= s2;
          hold <= 1'b1;
          hcnt <= '0;
        end
      end

    assign port_clk[p]  = clk_r;
    assign port_hold[p] = hold;
    assign port_cur[p]  = cur;
    assign port_rise[p] = nxt & ~clk_r;
  end

  logic [FRM_W-1:0] flen, flast, fcnt;
  logic             cod_oe_q;

  assign flen  = (frm_period_i == '0) ? FRM_W'(DEF_FRAME) : frm_period_i;
  assign flast = flen - 1'b1;

  always_ff @(posedge mclk or negedge rst_n)
    if (!rst_n) begin
      fcnt     <= '1;
      cod_oe_q <= 1'b0;
    end else begin
      cod_oe_q <= cod_oe_bit_i;
      if (port_hold[0])
        fcnt <= flast;
      else if (port_rise[0])
        fcnt <= (fcnt >= flast) ? '0 : fcnt + 1'b1;
    end

  assign pcm_clk_o    = port_clk[0];
  assign cod_clk_o    = port_clk[1];
  assign pcm_master_o = (port_cur[0] != 2'd0);
  assign pcm_frm_oe_o = pcm_master_o;
  assign pcm_frm_o    = pcm_master_o ? (pcm_clk_o && fcnt == '0) : pcm_frm_pin_i;
  assign cod_clk_oe_o = cod_oe_q;
endmodule

// File: rtl/pcm_codec_clksel_chk.sv
module pcm_codec_clksel_chk (
  input logic mclk,
  input logic rst_n,
  input logic cod_oe_bit_i,
  input logic pcm_clk_o,
  input logic pcm_master_o,
  input logic pcm_frm_o,
  input logic pcm_frm_oe_o,
  input logic cod_clk_oe_o
);
  // R5
  frm_in_high_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    (pcm_frm_oe_o && pcm_frm_o) |-> pcm_clk_o);

  // R5
  frm_rise_align_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    (pcm_master_o && $stable(pcm_master_o) && $rose(pcm_frm_o)) |-> $rose(pcm_clk_o));

  // R7
  cod_oe_off_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !$past(cod_oe_bit_i) |-> !cod_clk_oe_o);

  // R8
  role_flip_low_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !$stable(pcm_master_o) |-> !pcm_clk_o);
endmodule

bind pcm_codec_clksel pcm_codec_clksel_chk u_chk (
  .mclk(mclk), .rst_n(rst_n), .cod_oe_bit_i(cod_oe_bit_i),
  .pcm_clk_o(pcm_clk_o), .pcm_master_o(pcm_master_o),
  .pcm_frm_o(pcm_frm_o), .pcm_frm_oe_o(pcm_frm_oe_o),
  .cod_clk_oe_o(cod_clk_oe_o)
);

// File: tb/pcm_codec_clksel_test.sv
module pcm_codec_clksel_test;
  localparam int CLK_PERIOD = 10;
  localparam int PLL_H = 3;
  localparam int PIN_H = 5;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       pll = 1'b0, pin = 1'b0, frm_pin = 1'b0, oe_bit = 1'b0;
  logic [1:0] pcm_src = 2'd0, cod_src = 2'd0;
  logic [7:0] pcm_mdiv = 8'd1, pcm_pdiv = 8'd1, cod_mdiv = 8'd1, cod_pdiv = 8'd1;
  logic [8:0] frm_period = 9'd4;
  logic       pcm_clk, cod_clk, master, frm, frm_oe, cod_oe;
  int         nchk = 0, nfail = 0, pc = 0, ec = 0;

  pcm_codec_clksel uut (
    .mclk(clk), .rst_n(rst_n), .pll_clk_i(pll), .pcm_clk_pin_i(pin),
    .pcm_frm_pin_i(frm_pin), .pcm_src_i(pcm_src), .cod_src_i(cod_src),
    .pcm_mdiv_i(pcm_mdiv), .pcm_pdiv_i(pcm_pdiv), .cod_mdiv_i(cod_mdiv),
    .cod_pdiv_i(cod_pdiv), .frm_period_i(frm_period), .cod_oe_bit_i(oe_bit),
    .pcm_clk_o(pcm_clk), .cod_clk_o(cod_clk), .pcm_master_o(master),
    .pcm_frm_o(frm), .pcm_frm_oe_o(frm_oe), .cod_clk_oe_o(cod_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (pc == PLL_H - 1) begin pc <= 0; pll <= ~pll; end else pc <= pc + 1;
    if (ec == PIN_H - 1) begin ec <= 0; pin <= ~pin; end else ec <= ec + 1;
  end

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic chk_min(input string r, input int act, input int lim);
    nchk++;
    if (act < lim) begin
      nfail++;
      $display("FAIL %s actual=%0d expected>=%0d", r, act, lim);
    end
  endtask

  function automatic logic sig(input int w);
    case (w)
      0: return pcm_clk;
      1: return cod_clk;
      default: return frm;
    endcase
  endfunction

  task automatic meas(input int w, output int hi, output int lo);
    @(negedge clk);
    while (sig(w)) @(negedge clk);
    while (!sig(w)) @(negedge clk);
    hi = 0;
    while (sig(w)) begin hi++; @(negedge clk); end
    lo = 0;
    while (!sig(w)) begin lo++; @(negedge clk); end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int hi, lo, eh, g;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 pcm_clk", int'(pcm_clk), 0);
    chk("R9 cod_clk", int'(cod_clk), 0);
    chk("R9 master", int'(master), 0);
    chk("R9 cod_oe", int'(cod_oe), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 pcm_clk after", int'(pcm_clk), 0);
    chk("R9 master after", int'(master), 0);

    // R7 codec driver off until enabled
    repeat (20) @(negedge clk);
    chk("R7 oe off", int'(cod_oe), 0);
    oe_bit = 1'b1;
    @(negedge clk);
    chk("R7 oe on", int'(cod_oe), 1);
    oe_bit = 1'b0;
    @(negedge clk);
    chk("R7 oe off again", int'(cod_oe), 0);

    // R1 R2 R10 R3 sweep
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 4; s++)
        for (int d = 0; d < 4; d++) begin
          string tag;
          @(negedge clk);
          if (p == 0) begin
            pcm_src = 2'(s); pcm_mdiv = 8'(d); pcm_pdiv = 8'(d);
          end else begin
            cod_src = 2'(s); cod_mdiv = 8'(d); cod_pdiv = 8'(d);
          end
          repeat (4) @(negedge clk);
          meas(p, hi, lo);
          meas(p, hi, lo);
          eh = (s == 0) ? PIN_H :
               (s == 1) ? ((d == 0) ? 1 : d) :
               (s == 2) ? ((d == 0) ? 1 : d) * 2 * PLL_H : PLL_H;
          tag = (s == 0 && p == 1) ? "R2" : (d == 0 && (s == 1 || s == 2)) ? "R10" : "R1";
          chk($sformatf("%s port%0d src%0d div%0d high", tag, p, s, d), hi, eh);
          chk($sformatf("%s port%0d src%0d div%0d low", tag, p, s, d), lo, eh);
          if (p == 0) begin
            chk($sformatf("R3 master src%0d", s), int'(master), int'(s != 0));
            chk($sformatf("R3 frm_oe src%0d", s), int'(frm_oe), int'(s != 0));
          end
        end

    // R8 switch pll direct -> master div 4
    @(negedge clk);
    pcm_src = 2'd3;
    repeat (4) @(negedge clk);
    meas(0, hi, lo);
    while (!pcm_clk) @(negedge clk);
    pcm_src = 2'd1; pcm_mdiv = 8'd4;
    hi = 0;
    while (pcm_clk) begin hi++; @(negedge clk); end
    chk("R8 old pulse complete", hi, PLL_H);
    g = 0;
    while (!pcm_clk) begin g++; @(negedge clk); end
    chk_min("R8 low gap", g, 2 * 8);
    hi = 0;
    while (pcm_clk) begin hi++; @(negedge clk); end
    chk("R8 first new pulse", hi, 4);
    // R8 reverse switch
    while (!pcm_clk) @(negedge clk);
    pcm_src = 2'd3;
    hi = 0;
    while (pcm_clk) begin hi++; @(negedge clk); end
    chk("R8 old pulse complete rev", hi, 4);
    g = 0;
    while (!pcm_clk) begin g++; @(negedge clk); end
    chk_min("R8 low gap rev", g, 2 * 2 * PLL_H);
    hi = 0;
    while (pcm_clk) begin hi++; @(negedge clk); end
    chk("R8 first new pulse rev", hi, PLL_H);

    // R4 slave pass-through
    @(negedge clk);
    pcm_src = 2'd0;
    repeat (60) @(negedge clk);
    chk("R4 frm_oe slave", int'(frm_oe), 0);
    for (int v = 0; v < 4; v++) begin
      frm_pin = 1'(v % 2 == 0);
      #(CLK_PERIOD/4);
      chk($sformatf("R4 pass %0d", v), int'(frm), int'(v % 2 == 0));
      @(negedge clk);
    end
    frm_pin = 1'b0;

    // R5 master frame pulse
    pcm_src = 2'd1; pcm_mdiv = 8'd1;
    for (int f = 1; f < 5; f++) begin
      int bad;
      frm_period = 9'(f);
      repeat (30) @(negedge clk);
      meas(2, hi, lo);
      meas(2, hi, lo);
      chk($sformatf("R5 width period%0d", f), hi, 1);
      chk($sformatf("R5 gap period%0d", f), lo, 2 * f - 1);
      bad = 0;
      for (int k = 0; k < 40; k++) begin
        if (frm && !pcm_clk) bad++;
        @(negedge clk);
      end
      chk($sformatf("R5 inside high period%0d", f), bad, 0);
    end

    // R6 default period
    frm_period = 9'd0;
    meas(2, hi, lo);
    meas(2, hi, lo);
    chk("R6 width", hi, 1);
    chk("R6 gap", lo, 2 * 256 - 1);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule